// File: doc/BRIEF.md
# Event Timer Main Counter Register Front End

This block is the register front end of a high-precision event timer. It holds a read-only capabilities word, a general configuration register with a global run bit and a legacy-route bit, and a 32-bit main counter. The counter advances once every `CLK_DIV` core clocks while the run bit is set. With a 100 MHz core clock and the default divider, that is a 10 MHz tick. Software reaches the registers through a simple synchronous port. Each request carries a byte offset inside a 1 KiB window and an access size of 4 or 8 bytes.

Each access is checked for size and natural alignment. A 4-byte access with offset bit 2 set is steered to the upper half of the addressed 64-bit register. The per-timer comparator blocks sit next to this one. They see the running count, the run and legacy-route bits, and two one-cycle pulses. One pulse tells them to reschedule and the other tells them to stop.

Top module: `ev_timer_regs`

## Requirements
- R1: After synchronous reset the main count, the run bit, the legacy-route bit, the read data and both pulses are all zero.
- R2: A read of the 64-bit word at offset 0x000 returns the capabilities word, laid out as follows:
  - bits 63:32 hold the tick period in femtoseconds (100,000,000);
  - bits 31:16 hold 0x8086;
  - bit 15, the legacy-route capability, is 1;
  - bit 13, the 64-bit counter flag, is 0;
  - bits 12:8 hold the timer count minus one (7);
  - bits 7:0 hold revision 1;
  - every other bit is 0.
- R3: Writes to offset 0x000 change nothing; the capabilities word reads back unchanged.
- R4: The configuration register is at offset 0x010. Bit 0 is the run bit and bit 1 is the legacy-route bit. All other bits read as zero and ignore writes.
- R5: While the run bit is set, the count rises by one every `CLK_DIV` clocks. The first step comes `CLK_DIV` clocks after the write that set the bit. The count is frozen while the bit is clear, and it wraps from 0xFFFFFFFF to 0.
- R6: The counter sits at offset 0x0F0 and reads back zero-extended to 64 bits. A write merges the data into the zero-extended count under the lane mask and keeps the low 32 bits, so a write to only the upper half leaves the count unchanged.
- R7: Only 4-byte and 8-byte accesses whose offset is a multiple of their size are accepted. Any other write changes nothing, and any other read returns zero.
- R8: A 4-byte access with offset bit 2 set reaches bits 63:32. Its write data is moved up by 32 and its read data is moved down by 32. With bit 2 clear, the access reaches bits 31:0.
- R9: Reads at offsets other than those of the three registers return zero.
- R10: `sched_start` pulses for one cycle after either of these events:
  - a write that changes the run bit from 0 to 1;
  - any accepted counter write made while the run bit is set.

  `sched_stop` pulses for one cycle after a write that changes the run bit from 1 to 0.
- R11: Read data appears on `rsp_rdata` in the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | 10 | Byte offset inside the register window |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, right-aligned for 4-byte accesses |
| rsp_rdata | output | 64 | Read data, registered |
| main_count | output | 32 | Current main counter value |
| count_en | output | 1 | Run bit |
| legacy_route | output | 1 | Legacy-route bit |
| sched_start | output | 1 | One-cycle pulse: comparators reschedule |
| sched_stop | output | 1 | One-cycle pulse: comparators stop |

## Verification
The hardest case to reach is a write that arrives while the counter is running. Such a write has to land at a known prescaler phase and interact with the tick that was due in the same cycle. The stimulus starts the counter, lets it run for a number of clocks that is not a multiple of the divider, and then loads it through a 4-byte low-lane write and a 4-byte high-lane write. The wrap case is reached by loading 0xFFFFFFFF while the counter is stopped and then starting it. A per-clock reference model carries the prescaler phase across each of these writes.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CAP  = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic        ok;     // size and alignment accepted
        logic        hi;     // 4-byte access to the upper lane
        reg_sel_e    sel;    // addressed register
        logic [63:0] mask;   // lanes touched by a write
        logic [63:0] data;   // write data moved into its lane
    } access_t;

    localparam int unsigned OFS_CAP = 'h000;
    localparam int unsigned OFS_CFG = 'h010;
    localparam int unsigned OFS_CNT = 'h0F0;

    localparam int unsigned CFG_RUN_BIT = 0;
    localparam int unsigned CFG_LEG_BIT = 1;

    function automatic logic [63:0] cap_word(input int unsigned n_timers,
                                             input int unsigned tick_fs,
                                             input int unsigned rev);
        logic [63:0] w;
        w          = '0;
        w[63:32]   = tick_fs[31:0];
        w[31:16]   = 16'h8086;
        w[15]      = 1'b1;          // legacy-route capable
        w[13]      = 1'b0;          // 32-bit counter
        w[12:8]    = 5'(n_timers - 1);
        w[7:0]     = rev[7:0];
        return w;
    endfunction

endpackage

// File: rtl/ev_bus_decode.sv
module ev_bus_decode
    import evt_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [3:0]       size,
    input  logic [63:0]      wdata,
    output access_t          acc
);
    localparam int QW_W = OFS_W - 3;

    logic             size_ok;
    logic [QW_W-1:0]  qword;

    always_comb begin
        size_ok = (size == 4'd4 && ofs[1:0] == 2'b00) ||
                  (size == 4'd8 && ofs[2:0] == 3'b000);
        qword   = ofs[OFS_W-1:3];

        acc.ok  = size_ok;
        acc.hi  = (size == 4'd4) && ofs[2];

        if (size == 4'd8) begin
            acc.mask = '1;
            acc.data = wdata;
        end else if (acc.hi) begin
            acc.mask = {32'hFFFF_FFFF, 32'h0};
            acc.data = {wdata[31:0], 32'h0};
        end else begin
            acc.mask = {32'h0, 32'hFFFF_FFFF};
            acc.data = {32'h0, wdata[31:0]};
        end

        acc.sel = SEL_NONE;
        if (size_ok) begin
            if (qword == QW_W'(OFS_CAP >> 3))      acc.sel = SEL_CAP;
            else if (qword == QW_W'(OFS_CFG >> 3)) acc.sel = SEL_CFG;
            else if (qword == QW_W'(OFS_CNT >> 3)) acc.sel = SEL_CNT;
        end
    end
endmodule

// File: rtl/ev_main_count.sv
module ev_main_count #(
    parameter int CNT_W   = 32,
    parameter int CLK_DIV = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    logic tick;

    generate
        if (CLK_DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(CLK_DIV);
            logic [PW-1:0] presc;
            always_ff @(posedge clk) begin
                if (rst || load || restart)
                    presc <= '0;
                else if (en)
                    presc <= (presc == PW'(CLK_DIV - 1)) ? '0 : presc + 1'b1;
            end
            assign tick = (presc == PW'(CLK_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (en && tick && !restart)
            cnt <= cnt + 1'b1;
    end

    // R5
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(cnt));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ev_timer_regs.sv
module ev_timer_regs
    import evt_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int CLK_DIV    = 10,
    parameter int TICK_FS    = 100000000,
    parameter int REVISION   = 1,
    parameter int OFS_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [3:0]       req_size,
    input  logic [63:0]      req_wdata,
    output logic [63:0]      rsp_rdata,
    output logic [31:0]      main_count,
    output logic             count_en,
    output logic             legacy_route,
    output logic             sched_start,
    output logic             sched_stop
);
    localparam logic [63:0] CAP = cap_word(NUM_TIMERS, TICK_FS, REVISION);

    access_t     acc;
    logic        cfg_wr, cnt_wr, rd;
    logic [63:0] cfg_cur, cfg_new, cnt_new, rd_val;
    logic        run_rise, run_fall;

    ev_bus_decode #(.OFS_W(OFS_W)) u_dec (
        .ofs   (req_offset),
        .size  (req_size),
        .wdata (req_wdata),
        .acc   (acc)
    );

    always_comb begin
        cfg_wr   = req_valid && req_write && acc.sel == SEL_CFG;
        cnt_wr   = req_valid && req_write && acc.sel == SEL_CNT;
        rd       = req_valid && !req_write;
        cfg_cur  = '0;
        cfg_cur[CFG_RUN_BIT] = count_en;
        cfg_cur[CFG_LEG_BIT] = legacy_route;
        cfg_new  = (cfg_cur & ~acc.mask) | (acc.data & acc.mask);
        cnt_new  = ({32'h0, main_count} & ~acc.mask) | (acc.data & acc.mask);
        run_rise = cfg_wr && !count_en && cfg_new[CFG_RUN_BIT];
        run_fall = cfg_wr && count_en && !cfg_new[CFG_RUN_BIT];

        case (acc.sel)
            SEL_CAP: rd_val = CAP;
            SEL_CFG: rd_val = cfg_cur;
            SEL_CNT: rd_val = {32'h0, main_count};
            default: rd_val = '0;
        endcase
        if (acc.hi) rd_val = {32'h0, rd_val[63:32]};
    end

    ev_main_count #(.CNT_W(32), .CLK_DIV(CLK_DIV)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (count_en),
        .restart  (run_rise),
        .load     (cnt_wr),
        .load_val (cnt_new[31:0]),
        .cnt      (main_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_en     <= 1'b0;
            legacy_route <= 1'b0;
            sched_start  <= 1'b0;
            sched_stop   <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            if (cfg_wr) begin
                count_en     <= cfg_new[CFG_RUN_BIT];
                legacy_route <= cfg_new[CFG_LEG_BIT];
            end
            sched_start <= run_rise || (cnt_wr && count_en);
            sched_stop  <= run_fall;
            if (rd) rsp_rdata <= rd_val;
        end
    end

    // R10
    start_means_running_chk: assert property (@(posedge clk) disable iff (rst)
        sched_start |-> count_en);

    // R10
    stop_means_halted_chk: assert property (@(posedge clk) disable iff (rst)
        sched_stop |-> !count_en);

    // R7
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !acc.ok) |=> rsp_rdata == 64'h0);

    // R3
    cap_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && acc.sel == SEL_CAP) |=>
            ($stable(count_en) && $stable(legacy_route)));
endmodule

// File: tb/sim_ev_timer_regs.sv
`timescale 1ns/1ps
module sim_ev_timer_regs;
    localparam int DIV = 10;
    localparam logic [63:0] CAPW = 64'h05F5E100_80868701;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_write = 0;
    logic [9:0]  req_offset = '0;
    logic [3:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic [31:0] main_count;
    logic        count_en, legacy_route, sched_start, sched_stop;

    int vec = 0, bad = 0;

    // reference state
    logic [31:0] m_cnt = 0;
    int          m_presc = 0;
    bit          m_en = 0, m_leg = 0, m_start = 0, m_stop = 0;
    logic [63:0] m_rd = 0;

    always #5 clk = ~clk;

    ev_timer_regs u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .main_count(main_count), .count_en(count_en),
        .legacy_route(legacy_route), .sched_start(sched_start),
        .sched_stop(sched_stop)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string rtag);
        chk({rtag, " rdata"}, rsp_rdata, m_rd);
        chk("R5 count", 64'(main_count), 64'(m_cnt));
        chk("R4 run bit", 64'(count_en), 64'(m_en));
        chk("R4 legacy bit", 64'(legacy_route), 64'(m_leg));
        chk("R10 start pulse", 64'(sched_start), 64'(m_start));
        chk("R10 stop pulse", 64'(sched_stop), 64'(m_stop));
    endtask

    task automatic step(input bit v, input bit w, input logic [9:0] o,
                        input logic [3:0] s, input logic [63:0] d, input string tag);
        bit ok, hi, start, load;
        logic [63:0] mk, dt, rv, tmp;
        logic [9:0] base;
        logic [31:0] lv;
        bit nen, nleg;
        req_valid = v; req_write = w; req_offset = o; req_size = s; req_wdata = d;
        ok   = (s == 4 && o[1:0] == 0) || (s == 8 && o[2:0] == 0);
        hi   = (s == 4) && o[2];
        mk   = (s == 8) ? '1 : (hi ? {32'hFFFFFFFF, 32'h0} : {32'h0, 32'hFFFFFFFF});
        dt   = (s == 8) ? d  : (hi ? {d[31:0], 32'h0} : {32'h0, d[31:0]});
        base = {o[9:3], 3'b000};
        rv = 0;
        if (ok) begin
            if (base == 10'h000) rv = CAPW;
            else if (base == 10'h010) rv = {62'h0, m_leg, m_en};
            else if (base == 10'h0F0) rv = {32'h0, m_cnt};
            if (hi) rv = rv >> 32;
        end
        nen = m_en; nleg = m_leg; start = 0; load = 0; m_stop = 0; lv = 0;
        if (v && w && ok && base == 10'h010) begin
            tmp  = ({62'h0, m_leg, m_en} & ~mk) | (dt & mk);
            nen  = tmp[0]; nleg = tmp[1];
            start = !m_en && nen;
            m_stop = m_en && !nen;
        end
        if (v && w && ok && base == 10'h0F0) begin
            tmp  = ({32'h0, m_cnt} & ~mk) | (dt & mk);
            lv   = tmp[31:0];
            load = 1;
        end
        m_start = start || (load && m_en);
        if (load || start) begin
            m_presc = 0;
            if (load) m_cnt = lv;
        end else if (m_en) begin
            if (m_presc == DIV - 1) begin m_presc = 0; m_cnt = m_cnt + 1; end
            else m_presc++;
        end
        m_en = nen; m_leg = nleg;
        if (v && !w) m_rd = rv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        compare_all((v && !w) ? tag : "R11");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "R11");
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        compare_all("R1");                                     // R1 reset state

        step(1, 0, 10'h000, 8, 0, "R2");                       // R2 full caps
        step(1, 0, 10'h000, 4, 0, "R8");                       // R8 low lane
        step(1, 0, 10'h004, 4, 0, "R8");                       // R8 high lane
        step(1, 1, 10'h000, 8, '1, "R3");                      // R3 write caps
        step(1, 0, 10'h000, 8, 0, "R3");
        step(1, 1, 10'h010, 8, 64'hFFFF_FFFF_FFFF_FFFC, "R4"); // R4 reserved bits
        step(1, 0, 10'h010, 8, 0, "R4");
        step(1, 1, 10'h010, 4, 2, "R4");                       // legacy on
        step(1, 0, 10'h010, 8, 0, "R4");
        step(1, 1, 10'h0F0, 8, 64'hABCD_0000_0000_1234, "R6"); // R6 load, stopped
        idle(15);                                              // R5 frozen
        step(1, 0, 10'h0F0, 8, 0, "R6");
        step(1, 1, 10'h010, 8, 3, "R10");                      // R10 start
        idle(37);                                              // R5 running
        step(1, 0, 10'h0F0, 4, 0, "R6");
        step(1, 0, 10'h0F4, 4, 0, "R8");
        step(1, 1, 10'h0F4, 4, 64'hDEAD, "R6");                // R6 upper-only write
        idle(4);
        step(1, 1, 10'h014, 8, 0, "R7");                       // R7 misaligned 8B
        step(1, 0, 10'h010, 2, 0, "R7");                       // R7 bad size read
        step(1, 1, 10'h0F0, 1, 64'h77, "R7");                  // R7 bad size write
        step(1, 0, 10'h0F2, 4, 0, "R7");                       // R7 misaligned read
        step(1, 0, 10'h100, 8, 0, "R9");                       // R9 unmapped
        step(1, 0, 10'h3F8, 8, 0, "R9");
        idle(6);
        step(1, 1, 10'h0F0, 4, 64'h55, "R10");                 // R10 restart on load
        idle(13);
        step(1, 1, 10'h010, 4, 0, "R10");                      // R10 stop
        idle(12);
        step(1, 1, 10'h0F0, 4, 64'hFFFF_FFFF, "R5");           // R5 wrap setup
        step(1, 1, 10'h010, 8, 1, "R5");
        idle(25);
        step(1, 0, 10'h0F0, 8, 0, "R5");
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule